// File: doc/BRIEF.md
# Atomic Semaphore Scratch Register Bank

This block holds five scratch registers that software uses for locks and flags. Each register has two addresses. At its plain address it is ordinary storage. At its atomic address it provides one of two indivisible operations. Registers 0, 1 and 2 are 64 bits wide, and their atomic address gives compare-to-zero-and-swap: a write lands only when the register currently holds zero. Registers 3 and 4 are single bits, and their atomic address gives test-and-set: a read returns the old bit and leaves the bit at 1.

Requests arrive on a single-cycle port with enable, write flag, a byte offset within the block window and 64-bit write data. Every request finishes in the cycle it is presented. Read data is registered. It appears on the cycle after the read and holds until the next read.

Top module: `sema_scratch_bank`

## Requirements
- R1: At its plain offset (0x8000 + 8*i for register i = 0..4), each register is read/write storage. Read data appears on `rdData` one cycle after the read is presented and holds until the next read.
- R2: Reset clears register 0, both bit registers and `rdData`. Registers 1 and 2 keep their contents through reset.
- R3: A write to a compare-to-zero alias (0x8040, 0x8048, 0x8050 for registers 0, 1, 2) updates the register only if it currently holds zero. Otherwise the write is dropped.
- R4: A read from a compare-to-zero alias returns the register contents and changes nothing.
- R5: A read from a test-and-set alias (0x8058 for register 3, 0x8060 for register 4) returns the old bit in bit 0 and leaves the bit at 1.
- R6: A write to a test-and-set alias acts exactly like a write at the plain offset, so writing 0 there releases the lock.
- R7: The bit registers store only `wrData[0]`. Bits 63:1 of a read from them are always zero.
- R8: Any other offset, including misaligned ones such as 0x8004, is unmapped. A read there returns zero and a write there changes no register.
- R9: Operations on consecutive cycles take effect in order. A read sees the result of the operation in the cycle before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accEn | input | 1 | Request valid this cycle |
| accWr | input | 1 | 1 = write, 0 = read |
| accAddr | input | 16 | Byte offset within the block window |
| wrData | input | 64 | Write data |
| rdData | output | 64 | Registered read data |

## Verification
A read's data is due on `rdData` exactly one clock edge after the edge that accepts it. A write or a test-and-set side effect is visible to a read accepted on the very next edge. The bench drives each request at a falling edge. It checks the previous read's data at the next falling edge, just before it drives the following request. Because of this, back-to-back sequences are checked without idle gaps, and so is the hold of `rdData` across writes.

// File: rtl/sema_pkg.sv
package sema_pkg;
  localparam int NUM_WIDE = 3;
  localparam int NUM_BIT  = 2;
  localparam int NUM_REG  = NUM_WIDE + NUM_BIT;

  typedef struct packed {
    logic [NUM_REG-1:0] wrEn;   // store wrData into register
    logic [NUM_BIT-1:0] setEn;  // test-and-set side effect
    logic [NUM_REG-1:0] rdSel;  // register feeding the read mux
    logic               rdEn;   // capture read data
  } semaStrobe_t;
endpackage

// File: rtl/sema_ctrl.sv
module sema_ctrl
  import sema_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BASE_OFF  = 'h8000,
  parameter int ALIAS_GAP = 'h40,
  parameter int STRIDE    = 8
) (
  input  logic               accEn,
  input  logic               accWr,
  input  logic [ADDR_W-1:0]  accAddr,
  input  logic [NUM_REG-1:0] isZero,
  output semaStrobe_t        strb
);
  logic rdReq, wrReq;
  logic [NUM_REG-1:0] hitNorm, hitAtom, wrAllow;

  assign rdReq = accEn & ~accWr;
  assign wrReq = accEn & accWr;

  for (genvar i = 0; i < NUM_REG; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] NORM_A = ADDR_W'(BASE_OFF + STRIDE * i);
    localparam logic [ADDR_W-1:0] ATOM_A = ADDR_W'(BASE_OFF + ALIAS_GAP + STRIDE * i);
    assign hitNorm[i] = (accAddr == NORM_A);
    assign hitAtom[i] = (accAddr == ATOM_A);
    if (i < NUM_WIDE) begin : g_wz
      assign wrAllow[i] = isZero[i];
    end else begin : g_rsz
      assign wrAllow[i] = 1'b1;
    end
  end

  assign strb.wrEn  = {NUM_REG{wrReq}} & (hitNorm | (hitAtom & wrAllow));
  assign strb.setEn = {NUM_BIT{rdReq}} & hitAtom[NUM_REG-1:NUM_WIDE]
                      & isZero[NUM_REG-1:NUM_WIDE];
  assign strb.rdSel = {NUM_REG{rdReq}} & (hitNorm | hitAtom);
  assign strb.rdEn  = rdReq;
endmodule

// File: rtl/sema_regs.sv
module sema_regs
  import sema_pkg::*;
#(
  parameter int DATA_W      = 64,
  parameter int NUM_RST_WIDE = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  semaStrobe_t        strb,
  input  logic [DATA_W-1:0]  wrData,
  output logic [NUM_REG-1:0] isZero,
  output logic [DATA_W-1:0]  rdData
);
  logic [DATA_W-1:0] wideVal [NUM_WIDE];
  logic [NUM_BIT-1:0] bitVal;
  logic [DATA_W-1:0] rdNext;

  for (genvar i = 0; i < NUM_WIDE; i++) begin : g_wide
    logic [DATA_W-1:0] q;
    if (i < NUM_RST_WIDE) begin : g_rst
      always_ff @(posedge clk) begin
        if (!rstN)              q <= '0;
        else if (strb.wrEn[i])  q <= wrData;
      end
    end else begin : g_norst
      always_ff @(posedge clk) begin
        if (strb.wrEn[i]) q <= wrData;
      end
    end
    assign wideVal[i] = q;
    assign isZero[i]  = (q == '0);
  end

  for (genvar j = 0; j < NUM_BIT; j++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rstN)                         bitVal[j] <= 1'b0;
      else if (strb.wrEn[NUM_WIDE + j])  bitVal[j] <= wrData[0];
      else if (strb.setEn[j])            bitVal[j] <= 1'b1;
    end
    assign isZero[NUM_WIDE + j] = ~bitVal[j];
  end

  always_comb begin
    rdNext = '0;
    for (int i = 0; i < NUM_WIDE; i++)
      if (strb.rdSel[i]) rdNext = rdNext | wideVal[i];
    for (int j = 0; j < NUM_BIT; j++)
      if (strb.rdSel[NUM_WIDE + j]) rdNext[0] = rdNext[0] | bitVal[j];
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdData <= '0;
    else if (strb.rdEn) rdData <= rdNext;
  end
endmodule

// File: rtl/sema_scratch_bank.sv
module sema_scratch_bank
  import sema_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int ADDR_W    = 16,
  parameter int BASE_OFF  = 'h8000,
  parameter int ALIAS_GAP = 'h40,
  parameter int STRIDE    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accEn,
  input  logic              accWr,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  semaStrobe_t        strb;
  logic [NUM_REG-1:0] isZero;

  sema_ctrl #(
    .ADDR_W(ADDR_W), .BASE_OFF(BASE_OFF), .ALIAS_GAP(ALIAS_GAP), .STRIDE(STRIDE)
  ) u_ctrl (
    .accEn(accEn), .accWr(accWr), .accAddr(accAddr), .isZero(isZero), .strb(strb)
  );

  sema_regs #(.DATA_W(DATA_W), .NUM_RST_WIDE(1)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .isZero(isZero), .rdData(rdData)
  );
endmodule

// File: rtl/sema_scratch_chk.sv
module sema_scratch_chk #(
  parameter int DATA_W    = 64,
  parameter int ADDR_W    = 16,
  parameter int BASE_OFF  = 'h8000,
  parameter int ALIAS_GAP = 'h40,
  parameter int STRIDE    = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              accEn,
  input logic              accWr,
  input logic [ADDR_W-1:0] accAddr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData
);
  localparam logic [ADDR_W-1:0] PLAIN0 = ADDR_W'(BASE_OFF);
  localparam logic [ADDR_W-1:0] PLAIN3 = ADDR_W'(BASE_OFF + 3 * STRIDE);
  localparam logic [ADDR_W-1:0] PLAIN4 = ADDR_W'(BASE_OFF + 4 * STRIDE);
  localparam logic [ADDR_W-1:0] TAS3   = ADDR_W'(BASE_OFF + ALIAS_GAP + 3 * STRIDE);
  localparam logic [ADDR_W-1:0] TAS4   = ADDR_W'(BASE_OFF + ALIAS_GAP + 4 * STRIDE);

  logic rdReq, bitRd, known;
  assign rdReq = accEn & ~accWr;
  assign bitRd = rdReq & (accAddr == PLAIN3 || accAddr == PLAIN4 ||
                          accAddr == TAS3   || accAddr == TAS4);
  always_comb begin
    known = 1'b0;
    for (int i = 0; i < 5; i++)
      if (accAddr == ADDR_W'(BASE_OFF + STRIDE * i) ||
          accAddr == ADDR_W'(BASE_OFF + ALIAS_GAP + STRIDE * i)) known = 1'b1;
  end

  // R7
  bit_hi_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitRd |=> rdData[DATA_W-1:1] == '0);

  // R8
  unmapped_rd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !known) |=> rdData == '0);

  // R1
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdReq |=> $stable(rdData));

  // R5
  tas_second_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && accAddr == TAS3 && $past(rdReq && accAddr == TAS3)) |=> rdData == DATA_W'(1));

  // R9
  wr_then_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && accAddr == PLAIN0 && $past(accEn && accWr && accAddr == PLAIN0))
    |=> rdData == $past(wrData, 2));

  // R2
  reset_rd_zero_chk: assert property (@(posedge clk) $rose(rstN) |-> rdData == '0);
endmodule

bind sema_scratch_bank sema_scratch_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE_OFF(BASE_OFF),
  .ALIAS_GAP(ALIAS_GAP), .STRIDE(STRIDE)
) u_chk (
  .clk(clk), .rstN(rstN), .accEn(accEn), .accWr(accWr),
  .accAddr(accAddr), .wrData(wrData), .rdData(rdData)
);

// File: tb/test_sema_scratch_bank.sv
module test_sema_scratch_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accEn = 1'b0;
  logic        accWr = 1'b0;
  logic [15:0] accAddr = '0;
  logic [63:0] wrData = '0;
  logic [63:0] rdData;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [63:0] mWide [3];
  logic        mBit  [2];
  bit          pendValid = 1'b0;
  logic [63:0] pendExp;
  string       pendReq;

  always #2 clk = ~clk;

  sema_scratch_bank i_sema_scratch_bank (
    .clk(clk), .rstN(rstN), .accEn(accEn), .accWr(accWr),
    .accAddr(accAddr), .wrData(wrData), .rdData(rdData)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    if (pendValid) check(pendReq, rdData, pendExp);
    pendValid = 1'b0;
  endtask

  // decode: kind 0 unmapped, 1 plain, 2 atomic
  function automatic void decode(input logic [15:0] a, output int kind, output int idx);
    kind = 0; idx = 0;
    for (int i = 0; i < 5; i++) begin
      if (a == 16'h8000 + 16'(8 * i)) begin kind = 1; idx = i; end
      if (a == 16'h8040 + 16'(8 * i)) begin kind = 2; idx = i; end
    end
  endfunction

  task automatic issue(input bit wr, input logic [15:0] a, input logic [63:0] d, input string req);
    int kind, idx;
    logic [63:0] exp;
    @(negedge clk);
    settle();
    accEn = 1'b1; accWr = wr; accAddr = a; wrData = d;
    decode(a, kind, idx);
    exp = '0;
    if (wr) begin
      if (kind != 0) begin
        if (idx < 3) begin
          if (kind == 1 || mWide[idx] == '0) mWide[idx] = d;
        end else mBit[idx-3] = d[0];
      end
    end else begin
      if (kind != 0) begin
        if (idx < 3) exp = mWide[idx];
        else begin
          exp = {63'd0, mBit[idx-3]};
          if (kind == 2) mBit[idx-3] = 1'b1;
        end
      end
      pendValid = 1'b1; pendExp = exp; pendReq = req;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    settle();
    accEn = 1'b0; accWr = 1'b0;
  endtask

  task automatic doReset();
    idle();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mWide[0] = '0; mBit[0] = 1'b0; mBit[1] = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    mWide[0] = '0; mWide[1] = '0; mWide[2] = '0; mBit[0] = 1'b0; mBit[1] = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R2 rdData after reset", rdData, 64'd0);

    // R2 reset values
    issue(0, 16'h8000, 0, "R2 reg0 reset");
    issue(0, 16'h8018, 0, "R2 reg3 reset");
    issue(0, 16'h8020, 0, "R2 reg4 reset");
    // R1 plain storage
    issue(1, 16'h8008, 64'hA5A5_0000_1234_5678, "R1");
    issue(1, 16'h8010, 64'h0, "R1");
    issue(0, 16'h8008, 0, "R1 reg1 readback");
    issue(1, 16'h8000, 64'hFFFF_0000_FFFF_0001, "R1");
    issue(0, 16'h8000, 0, "R1 reg0 readback");
    idle(); idle();
    check("R1 rdData holds while idle", rdData, 64'hFFFF_0000_FFFF_0001);
    // R3 compare-to-zero write
    issue(1, 16'h8048, 64'h1111, "R3");
    issue(0, 16'h8008, 0, "R3 nonzero blocks write");
    issue(1, 16'h8050, 64'h2222, "R3");
    issue(0, 16'h8010, 0, "R3 zero allows write");
    // R4 alias read no side effect
    issue(0, 16'h8050, 0, "R4 alias read");
    issue(0, 16'h8010, 0, "R4 no side effect");
    // R5 test-and-set, back-to-back (R9)
    issue(0, 16'h8058, 0, "R5 first tas");
    issue(0, 16'h8058, 0, "R9 second tas");
    issue(0, 16'h8018, 0, "R5 bit now set");
    issue(0, 16'h8020, 0, "R5 other bit untouched");
    // R6 release via alias write
    issue(1, 16'h8058, 64'h0, "R6");
    issue(0, 16'h8018, 0, "R6 release");
    // R7 reserved bits
    issue(1, 16'h8020, 64'hFFFF_FFFF_FFFF_FFFE, "R7");
    issue(0, 16'h8020, 0, "R7 only bit0 stored");
    issue(1, 16'h8060, 64'hFFFF_FFFF_FFFF_FFFF, "R7");
    issue(0, 16'h8060, 0, "R7 upper bits zero");
    // R8 unmapped
    issue(1, 16'h8004, 64'h0, "R8");
    issue(1, 16'h8028, 64'hDEAD_BEEF, "R8");
    issue(1, 16'h8068, 64'h0, "R8");
    issue(0, 16'h8004, 0, "R8 misaligned read");
    issue(0, 16'h8030, 0, "R8 unmapped read");
    for (int i = 0; i < 5; i++) issue(0, 16'h8000 + 16'(8 * i), 0, "R8 regs unchanged");
    // R9 write then read back-to-back, then compare-to-zero after clear
    issue(1, 16'h8000, 64'h0, "R9");
    issue(1, 16'h8040, 64'h77, "R9");
    issue(0, 16'h8000, 0, "R9 in-order wz");
    // R2 retention
    doReset();
    issue(0, 16'h8000, 0, "R2 reg0 cleared");
    issue(0, 16'h8008, 0, "R2 reg1 retained");
    issue(0, 16'h8010, 0, "R2 reg2 retained");
    issue(0, 16'h8020, 0, "R2 reg4 cleared");

    // random phase
    for (int n = 0; n < 600; n++) begin
      int sel;
      logic [15:0] a;
      logic [63:0] d;
      sel = int'($urandom % 12);
      if (sel < 5)       a = 16'h8000 + 16'(8 * sel);
      else if (sel < 10) a = 16'h8040 + 16'(8 * (sel - 5));
      else if (sel == 10) a = 16'h8004;
      else               a = 16'h8068;
      d = ($urandom % 3 == 0) ? 64'd0 : {$urandom, $urandom};
      issue(bit'($urandom % 2), a, d, "R9 random mix");
      if ($urandom % 8 == 0) idle();
    end
    idle(); idle();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule